// File: doc/BRIEF.md
# Two-Register Accumulator Processor Core

An 8-bit processor core with two working registers, A and B. It fetches one-byte opcodes and one-byte operands over an 8-bit-addressed synchronous memory bus and runs each instruction through a multi-state control machine. The core holds the program counter, instruction register, memory address register, A, B, a four-bit condition-code register, a small ALU and the control unit. Program memory, data memory and port decoding are outside the core.

Memory reads have one cycle of latency. The address the core drives in one cycle returns data in the next cycle. Each instruction therefore spends one state on an address and picks up the byte in the state after it. Each instruction first takes three fetch states and one decode state. It then runs its own short execute sequence and returns to fetch.

The instruction set has immediate and direct loads for A and B, direct stores for A and B, an unconditional branch, A/B add, AND and OR, and increment and decrement of either register.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, `addr_o` is 0x00, `we_o` is 0 and `ccr_o` is 0. After reset, PC, A, B and flags are zero, and the first opcode is fetched from address 0x00.
- R2: Instructions run in address order. PC steps once past the opcode and once past each operand byte, so the next opcode is read from the byte after the last operand.
- R3: Immediate loads place the byte after the opcode into the register: 0x86 for A, 0x88 for B.
- R4: Direct loads use the byte after the opcode as an address and load the register from that address: 0x87 for A, 0x89 for B.
- R5: Direct stores write the register to the address given by the byte after the opcode: 0x96 for A, 0x97 for B. `we_o` is high for exactly one cycle per store.
- R6: Opcode 0x20 (branch) loads PC with the byte after the opcode.
- R7: Opcode 0x42 writes A+B into A. `ccr_o` = {N,Z,V,C} in bits 3..0: N is result bit 7, Z is a zero result, V is signed overflow and C is carry out.
- R8: Opcode 0x44 writes A AND B into A, and opcode 0x45 writes A OR B into A. Both set N and Z from the result and clear V and C.
- R9: Increment and decrement work in place: 0x46 is A+1, 0x47 is B+1, 0x48 is A-1, 0x49 is B-1. Each updates all four flags. On increment, C is the carry out. On decrement, C is the borrow. V marks signed overflow (0x7F to 0x80, or 0x80 to 0x7F).
- R10: Loads, stores and branches leave `ccr_o` unchanged.
- R11: An opcode outside the set above is a one-byte no-op, and execution continues at the next byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| addr_o | output | 8 | Memory address |
| rdata_i | input | 8 | Read data, valid one cycle after its address |
| wdata_o | output | 8 | Write data |
| we_o | output | 1 | Write enable |
| ccr_o | output | 4 | Condition codes {N,Z,V,C} |

## Verification
A store's write cycle and the fetch of the next instruction can target the same byte. The bench provokes this with a program that stores an increment opcode into the location it executes next. The test passes only if the stored value is the opcode that runs, which shows in the final A. In the ALU state, the register write and the flag update land in the same cycle. A load that follows an ALU instruction must then leave those flags alone. The bench judges both by the flags and the stored results at the ports.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int FW = 4;
  typedef logic [DW-1:0] byte_t;

  localparam byte_t OP_LDA_I = 8'h86;
  localparam byte_t OP_LDA_D = 8'h87;
  localparam byte_t OP_LDB_I = 8'h88;
  localparam byte_t OP_LDB_D = 8'h89;
  localparam byte_t OP_STA_D = 8'h96;
  localparam byte_t OP_STB_D = 8'h97;
  localparam byte_t OP_ADD   = 8'h42;
  localparam byte_t OP_AND   = 8'h44;
  localparam byte_t OP_OR    = 8'h45;
  localparam byte_t OP_INCA  = 8'h46;
  localparam byte_t OP_INCB  = 8'h47;
  localparam byte_t OP_DECA  = 8'h48;
  localparam byte_t OP_DECB  = 8'h49;
  localparam byte_t OP_BRA   = 8'h20;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_DEC, S_OP0, S_OP1, S_IMM,
    S_DADR, S_DWAIT, S_DLD, S_STWR, S_BRLD, S_ALU
  } state_e;

  typedef enum logic [2:0] {ALU_ADD, ALU_AND, ALU_OR, ALU_INC, ALU_DEC} alu_op_e;

  typedef enum logic [2:0] {C_LDI, C_LDD, C_ST, C_BRA, C_ALU, C_NOP} iclass_e;

  typedef struct packed {
    logic    mar_ld;
    logic    mar_bus;
    logic    pc_inc;
    logic    pc_ld;
    logic    ir_ld;
    logic    a_ld;
    logic    b_ld;
    logic    from_alu;
    logic    ccr_ld;
    logic    we;
    logic    sel_b;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
(
  input  alu_op_e       op_i,
  input  byte_t         x_i,
  input  byte_t         y_i,
  output byte_t         res_o,
  output logic [FW-1:0] flg_o
);
  localparam int MSB = DW - 1;
  logic [DW:0] wide;
  logic        v;
  byte_t       one;

  assign one = byte_t'(1);

  always_comb begin
    wide = '0;
    v    = 1'b0;
    case (op_i)
      ALU_ADD: begin
        wide = {1'b0, x_i} + {1'b0, y_i};
        v    = (x_i[MSB] == y_i[MSB]) && (wide[MSB] != x_i[MSB]);
      end
      ALU_AND: wide = {1'b0, x_i & y_i};
      ALU_OR:  wide = {1'b0, x_i | y_i};
      ALU_INC: begin
        wide = {1'b0, x_i} + {1'b0, one};
        v    = !x_i[MSB] && wide[MSB];
      end
      ALU_DEC: begin
        wide = {1'b0, x_i} - {1'b0, one};
        v    = x_i[MSB] && !wide[MSB];
      end
      default: wide = '0;
    endcase
  end

  assign res_o = wide[DW-1:0];
  assign flg_o = {wide[MSB], (wide[DW-1:0] == '0), v, wide[DW]};
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t ir_i,
  output ctrl_t ctl_o
);
  state_e  st_q, st_d;
  iclass_e cls;
  logic    tgt_b;
  alu_op_e aop;

  always_comb begin
    cls   = C_NOP;
    tgt_b = 1'b0;
    aop   = ALU_ADD;
    case (ir_i)
      OP_LDA_I: cls = C_LDI;
      OP_LDB_I: begin cls = C_LDI; tgt_b = 1'b1; end
      OP_LDA_D: cls = C_LDD;
      OP_LDB_D: begin cls = C_LDD; tgt_b = 1'b1; end
      OP_STA_D: cls = C_ST;
      OP_STB_D: begin cls = C_ST;  tgt_b = 1'b1; end
      OP_BRA:   cls = C_BRA;
      OP_ADD:   cls = C_ALU;
      OP_AND:   begin cls = C_ALU; aop = ALU_AND; end
      OP_OR:    begin cls = C_ALU; aop = ALU_OR;  end
      OP_INCA:  begin cls = C_ALU; aop = ALU_INC; end
      OP_INCB:  begin cls = C_ALU; aop = ALU_INC; tgt_b = 1'b1; end
      OP_DECA:  begin cls = C_ALU; aop = ALU_DEC; end
      OP_DECB:  begin cls = C_ALU; aop = ALU_DEC; tgt_b = 1'b1; end
      default:  cls = C_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_F0;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d = S_F0;
    case (st_q)
      S_F0:    st_d = S_F1;
      S_F1:    st_d = S_F2;
      S_F2:    st_d = S_DEC;
      S_DEC: begin
        if (cls == C_ALU)      st_d = S_ALU;
        else if (cls == C_NOP) st_d = S_F0;
        else                   st_d = S_OP0;
      end
      S_OP0:   st_d = S_OP1;
      S_OP1: begin
        if (cls == C_LDI)      st_d = S_IMM;
        else if (cls == C_BRA) st_d = S_BRLD;
        else                   st_d = S_DADR;
      end
      S_DADR:  st_d = (cls == C_ST) ? S_STWR : S_DWAIT;
      S_DWAIT: st_d = S_DLD;
      default: st_d = S_F0;
    endcase
  end

  always_comb begin
    ctl_o        = '0;
    ctl_o.alu_op = aop;
    ctl_o.sel_b  = tgt_b;
    case (st_q)
      S_F0, S_OP0: ctl_o.mar_ld = 1'b1;
      S_F1, S_OP1: ctl_o.pc_inc = 1'b1;
      S_F2:        ctl_o.ir_ld  = 1'b1;
      S_IMM, S_DLD: begin
        ctl_o.a_ld = !tgt_b;
        ctl_o.b_ld = tgt_b;
      end
      S_DADR: begin
        ctl_o.mar_ld  = 1'b1;
        ctl_o.mar_bus = 1'b1;
      end
      S_STWR: ctl_o.we = 1'b1;
      S_BRLD: ctl_o.pc_ld = 1'b1;
      S_ALU: begin
        ctl_o.a_ld     = !tgt_b;
        ctl_o.b_ld     = tgt_b;
        ctl_o.from_alu = 1'b1;
        ctl_o.ccr_ld   = 1'b1;
      end
      default: ;
    endcase
  end

  // R2: decode always follows the third fetch state
  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_F2) |=> (st_q == S_DEC));
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_cpu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctl_i,
  input  byte_t         rdata_i,
  output byte_t         ir_o,
  output logic [AW-1:0] addr_o,
  output byte_t         wdata_o,
  output logic          we_o,
  output logic [FW-1:0] ccr_o
);
  logic [AW-1:0] pc_q, pc_d, mar_q, mar_d;
  byte_t         ir_q, a_q, a_d, b_q, b_d, alu_x, alu_res, ld_val;
  logic [FW-1:0] ccr_q, alu_flg;

  assign alu_x  = ctl_i.sel_b ? b_q : a_q;
  assign ld_val = ctl_i.from_alu ? alu_res : rdata_i;

  acc_alu u_alu (
    .op_i  (ctl_i.alu_op),
    .x_i   (alu_x),
    .y_i   (b_q),
    .res_o (alu_res),
    .flg_o (alu_flg)
  );

  always_comb begin
    pc_d = pc_q;
    if (ctl_i.pc_ld)       pc_d = rdata_i[AW-1:0];
    else if (ctl_i.pc_inc) pc_d = pc_q + 1'b1;
    mar_d = ctl_i.mar_bus ? rdata_i[AW-1:0] : pc_q;
    a_d   = ld_val;
    b_d   = ld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      ccr_q <= '0;
    end else begin
      pc_q <= pc_d;
      if (ctl_i.mar_ld) mar_q <= mar_d;
      if (ctl_i.ir_ld)  ir_q  <= rdata_i;
      if (ctl_i.a_ld)   a_q   <= a_d;
      if (ctl_i.b_ld)   b_q   <= b_d;
      if (ctl_i.ccr_ld) ccr_q <= alu_flg;
    end
  end

  assign ir_o    = ir_q;
  assign addr_o  = mar_q;
  assign wdata_o = ctl_i.sel_b ? b_q : a_q;
  assign we_o    = ctl_i.we;
  assign ccr_o   = ccr_q;

  // R10: flags only move on an ALU cycle
  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_i.ccr_ld |=> $stable(ccr_q));
  // R6: branch target comes from the operand on the bus
  p_branch_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_i.pc_ld |=> (pc_q == $past(rdata_i[AW-1:0])));
  // R2: when the opcode lands, PC already points one past its address
  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_i.ir_ld |-> (pc_q == mar_q + 1'b1));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] addr_o,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] wdata_o,
  output logic          we_o,
  output logic [FW-1:0] ccr_o
);
  logic [SYNC_STAGES-1:0] rst_sr;
  logic                   rst_core_n;
  ctrl_t                  ctl;
  byte_t                  ir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= '0;
    else        rst_sr <= {rst_sr[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sr[SYNC_STAGES-1];

  acc_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_core_n),
    .ir_i  (ir),
    .ctl_o (ctl)
  );

  acc_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ctl_i   (ctl),
    .rdata_i (rdata_i),
    .ir_o    (ir),
    .addr_o  (addr_o),
    .wdata_o (wdata_o),
    .we_o    (we_o),
    .ccr_o   (ccr_o)
  );

  // R5: every store is a single write cycle
  p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    we_o |=> !we_o);
endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr, rdata, wdata;
  logic       we;
  logic [3:0] ccr;
  logic [7:0] mem [256];
  logic [7:0] img [256];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int we_run = 0;
  int we_max = 0;
  int pos = 0;

  always #5 clk = ~clk;

  acc_cpu dut (
    .clk(clk), .rst_n(rst_n), .addr_o(addr), .rdata_i(rdata),
    .wdata_o(wdata), .we_o(we), .ccr_o(ccr)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mem   <= img;
      rdata <= 8'h00;
    end else begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end

  always @(negedge clk) begin
    if (rst_n && we) we_run = we_run + 1;
    else we_run = 0;
    if (we_run > we_max) we_max = we_run;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wipe();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    pos = 0;
  endtask

  task automatic put(input logic [7:0] b);
    img[pos] = b;
    pos = pos + 1;
  endtask

  task automatic run(input int n);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    wipe();
    put(8'h86); put(8'h12);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 addr in reset", addr, 8'h00);
    check("R1 we in reset", {7'd0, we}, 8'h00);
    check("R1 flags in reset", {4'd0, ccr}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 first fetch address", addr, 8'h00);
  endtask

  task automatic t_imm_store();
    wipe();
    put(8'h86); put(8'h5A); put(8'h88); put(8'hC3);
    put(8'h96); put(8'h80); put(8'h97); put(8'h81);
    put(8'h20); put(8'h08);
    we_max = 0;
    run(150);
    check("R3 LDA imm via STA", mem[8'h80], 8'h5A);
    check("R3 LDB imm via STB", mem[8'h81], 8'hC3);
    check("R5 one-cycle write", 8'(we_max), 8'h01);
    check("R10 flags after loads", {4'd0, ccr}, 8'h00);
  endtask

  task automatic t_direct();
    wipe();
    put(8'h87); put(8'h90); put(8'h89); put(8'h91);
    put(8'h96); put(8'h82); put(8'h97); put(8'h83);
    put(8'h20); put(8'h08);
    img[8'h90] = 8'h7F; img[8'h91] = 8'h80;
    run(150);
    check("R4 LDA direct", mem[8'h82], 8'h7F);
    check("R4 LDB direct", mem[8'h83], 8'h80);
  endtask

  task automatic t_add();
    wipe();
    put(8'h86); put(8'h7F); put(8'h88); put(8'h01); put(8'h42);
    put(8'h96); put(8'h80); put(8'h86); put(8'h00); put(8'h96); put(8'h81);
    put(8'h20); put(8'h0B);
    run(200);
    check("R7 add sum", mem[8'h80], 8'h80);
    check("R10 flags kept N,V after load zero", {4'd0, ccr}, 8'h0A);
    wipe();
    put(8'h86); put(8'hFF); put(8'h88); put(8'h01); put(8'h42);
    put(8'h96); put(8'h80); put(8'h20); put(8'h07);
    run(150);
    check("R7 add wrap", mem[8'h80], 8'h00);
    check("R7 add flags Z,C", {4'd0, ccr}, 8'h05);
  endtask

  task automatic t_logic();
    wipe();
    put(8'h86); put(8'hFF); put(8'h88); put(8'h01); put(8'h42);
    put(8'h86); put(8'hF0); put(8'h88); put(8'h0F); put(8'h45);
    put(8'h96); put(8'h80); put(8'h20); put(8'h0C);
    run(200);
    check("R8 or result", mem[8'h80], 8'hFF);
    check("R8 or flags N, C cleared", {4'd0, ccr}, 8'h08);
    wipe();
    put(8'h86); put(8'hF0); put(8'h88); put(8'h0F); put(8'h44);
    put(8'h96); put(8'h80); put(8'h20); put(8'h07);
    run(150);
    check("R8 and result", mem[8'h80], 8'h00);
    check("R8 and flags Z", {4'd0, ccr}, 8'h04);
  endtask

  task automatic t_incdec();
    wipe();
    put(8'h86); put(8'hFF); put(8'h46); put(8'h96); put(8'h80); put(8'h20); put(8'h05);
    run(150);
    check("R9 INCA wrap", mem[8'h80], 8'h00);
    check("R9 INCA flags Z,C", {4'd0, ccr}, 8'h05);
    wipe();
    put(8'h88); put(8'h00); put(8'h49); put(8'h97); put(8'h80); put(8'h20); put(8'h05);
    run(150);
    check("R9 DECB wrap", mem[8'h80], 8'hFF);
    check("R9 DECB flags N,C", {4'd0, ccr}, 8'h09);
    wipe();
    put(8'h88); put(8'h7F); put(8'h47); put(8'h97); put(8'h80); put(8'h20); put(8'h05);
    run(150);
    check("R9 INCB overflow", mem[8'h80], 8'h80);
    check("R9 INCB flags N,V", {4'd0, ccr}, 8'h0A);
    wipe();
    put(8'h86); put(8'h80); put(8'h48); put(8'h96); put(8'h80); put(8'h20); put(8'h05);
    run(150);
    check("R9 DECA overflow", mem[8'h80], 8'h7F);
    check("R9 DECA flags V", {4'd0, ccr}, 8'h02);
  endtask

  task automatic t_branch_nop();
    wipe();
    put(8'h20); put(8'h10); put(8'h86); put(8'hEE); put(8'h96); put(8'h80);
    img[8'h10] = 8'h86; img[8'h11] = 8'h33; img[8'h12] = 8'h96;
    img[8'h13] = 8'h80; img[8'h14] = 8'h20; img[8'h15] = 8'h14;
    run(150);
    check("R6 branch skips", mem[8'h80], 8'h33);
    wipe();
    put(8'h86); put(8'h11); put(8'hFF); put(8'h00); put(8'h96); put(8'h80);
    put(8'h20); put(8'h06);
    run(150);
    check("R11 unknown opcodes skipped", mem[8'h80], 8'h11);
  endtask

  task automatic t_selfmod();
    wipe();
    put(8'h86); put(8'h46); put(8'h96); put(8'h04); put(8'h00);
    put(8'h96); put(8'h80); put(8'h20); put(8'h07);
    run(150);
    check("R2 stored opcode runs next", mem[8'h80], 8'h47);
    check("R5 store hit code byte", mem[8'h04], 8'h46);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    t_reset();
    t_imm_store();
    t_direct();
    t_add();
    t_logic();
    t_incdec();
    t_branch_nop();
    t_selfmod();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule